// File: doc/BRIEF.md
# Split-Nibble Bidirectional Port with Strobed Handshake

This block drives the pins of an eight-bit bidirectional port that is split into two nibbles. Each nibble is set independently to input, general output, or address output. In address output the nibble carries address bits supplied by the bus controller, so a system that needs only twelve address bits can drive address on the lower nibble and keep the upper nibble as general I/O. After reset every bit is an input. Each bit has a pull-up enable that is dropped whenever that bit drives its pin. A per-nibble option removes the pull-up entirely.

A strobed handshake mode adds two lines: an active-low data-available strobe and a ready line. Which way data moves is set by the upper nibble. When the upper nibble is an output, the port sends data: it drives the strobe and watches ready. When the upper nibble is an input, the port receives data: it watches the strobe and drives ready. While the handshake is active, the lower nibble takes the upper nibble's mode, whatever was written for it. The strobe and ready inputs pass through a synchronizer of `SYNC_DEPTH` flops before the handshake logic acts on them.

Software uses one write port with two targets: the configuration register (`wr_sel`=0) and the output data register (`wr_sel`=1). It reads the input register through `rd_data`, and pulses `rd_strobe` to acknowledge a received byte.

Top module: `nibport`

## Requirements
- R1: While reset is held, `pad_oe` is all zeros, `rd_data` is zero, `dav_oe` and `rdy_oe` are low, `dav_n_out` is high, and `pullup_en` is set on exactly the bits of nibbles whose `PULLUP_MASK` bit is 1.
- R2: The configuration register holds the lower-nibble mode in bits [1:0], the upper-nibble mode in bits [3:2] and the handshake enable in bit 4. A mode field of 00 is input, 01 is output, 10 is address output, and 11 is treated as input. An output nibble drives its output data register bits with `pad_oe` set. An input nibble has `pad_oe` clear and `pad_out` zero.
- R3: A nibble in address mode drives the matching bits of `addr_nib` with `pad_oe` set, whatever the data register holds.
- R4: Each nibble's mode acts only on its own four bits. For example, the lower nibble can carry address while the upper nibble is general output or input.
- R5: For a nibble whose `PULLUP_MASK` bit is 1, `pullup_en` is the inverse of `pad_oe` bit for bit. For a nibble whose `PULLUP_MASK` bit is 0, `pullup_en` is always zero.
- R6: When the receive handshake is not active, `rd_data` equals `pad_in` as sampled at the previous clock edge.
- R7: The handshake is active when bit 4 is set and the upper nibble is not in address mode. While it is active, the lower nibble uses the upper nibble's mode. `dav_oe` is high exactly when the active handshake has an output upper nibble, and `rdy_oe` is high exactly when it has an input upper nibble.
- R8: In send handshake, an accepted data write sets `dav_n_out` low at the write's clock edge. `dav_n_out` stays low until `rdy_in` has been high, and it returns high SYNC_DEPTH+1 edges after `rdy_in` rises.
- R9: In send handshake, a data write is ignored while `dav_n_out` is low, and also until `rdy_in` has been back low for SYNC_DEPTH+1 edges. An ignored write leaves `pad_out` unchanged.
- R10: In receive handshake, `rdy_out` is high while the input register is empty. A falling edge on `dav_n_in` stores `pad_in` into `rd_data` and drops `rdy_out` SYNC_DEPTH+1 edges after the fall.
- R11: While the received byte is held, further falls on `dav_n_in` do not change `rd_data`. A `rd_strobe` pulse raises `rdy_out` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 configuration, 1 output data |
| wr_data | input | 8 | Write value |
| rd_strobe | input | 1 | Acknowledge that software has read the received byte |
| rd_data | output | 8 | Input register |
| addr_nib | input | 8 | Address bits from the bus controller, one nibble per port nibble |
| pad_in | input | 8 | Pin input levels |
| pad_out | output | 8 | Pin output levels |
| pad_oe | output | 8 | Pin output enables |
| pullup_en | output | 8 | Per-bit pull-up enables |
| dav_n_in | input | 1 | Data-available strobe from the peer, active low |
| dav_n_out | output | 1 | Data-available strobe to the peer, active low |
| dav_oe | output | 1 | Output enable for the strobe pin |
| rdy_in | input | 1 | Ready from the peer |
| rdy_out | output | 1 | Ready to the peer |
| rdy_oe | output | 1 | Output enable for the ready pin |

## Verification
Pin enables, pin levels and pull-ups depend only on the stored configuration and data. They therefore settle one edge after a write, and the bench checks them at the falling clock edge that follows the write. `rd_data` in plain input mode lags `pad_in` by one edge. Every handshake response is due SYNC_DEPTH+1 edges after its pin changes, because the synchronizer adds SYNC_DEPTH flops and the handshake state adds one more. The bench counts edges one at a time from the falling edge where it drives the pin, and it checks that the response has not appeared at any earlier edge. An acknowledge or a data write takes effect at the very next edge.

// File: rtl/nibport_pkg.sv
package nibport_pkg;
   typedef enum logic [1:0] {
      NM_IN     = 2'b00,
      NM_OUT    = 2'b01,
      NM_ADDR   = 2'b10,
      NM_ALT_IN = 2'b11
   } nib_mode_e;

   typedef enum logic [1:0] {
      OH_IDLE,
      OH_WAIT_RDY,
      OH_WAIT_REL
   } oh_state_e;

   localparam int CFG_W  = 5;
   localparam int LO_LSB = 0;
   localparam int UP_LSB = 2;
   localparam int HS_BIT = 4;

   function automatic nib_mode_e norm_mode(input logic [1:0] f);
      return (f == 2'b11) ? NM_IN : nib_mode_e'(f);
   endfunction
endpackage

// File: rtl/nibport_sync.sv
module nibport_sync #(
   parameter int   DEPTH   = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("nibport_sync: DEPTH must be at least 1");
      end
   endgenerate

   logic [DEPTH-1:0] stg;

   generate
      if (DEPTH == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg <= RST_VAL;
            else        stg <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg <= {DEPTH{RST_VAL}};
            else        stg <= {stg[DEPTH-2:0], d};
         end
      end
   endgenerate

   assign q = stg[DEPTH-1];
endmodule

// File: rtl/nibport_lane.sv
module nibport_lane
   import nibport_pkg::*;
#(
   parameter int NIB_W  = 4,
   parameter bit PU_OPT = 1'b1
) (
   input  nib_mode_e        mode,
   input  logic [NIB_W-1:0] data_bits,
   input  logic [NIB_W-1:0] addr_bits,
   output logic [NIB_W-1:0] pin_out,
   output logic [NIB_W-1:0] pin_oe,
   output logic [NIB_W-1:0] pu_en
);
   always_comb begin
      unique case (mode)
         NM_OUT: begin
            pin_out = data_bits;
            pin_oe  = '1;
         end
         NM_ADDR: begin
            pin_out = addr_bits;
            pin_oe  = '1;
         end
         default: begin
            pin_out = '0;
            pin_oe  = '0;
         end
      endcase
   end

   generate
      if (PU_OPT) begin : g_pu
         assign pu_en = ~pin_oe;
      end else begin : g_no_pu
         assign pu_en = '0;
      end
   endgenerate
endmodule

// File: rtl/nibport_hs.sv
module nibport_hs
   import nibport_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic out_hs,
   input  logic in_hs,
   input  logic data_wr,
   input  logic rd_strobe,
   input  logic dav_sync,
   input  logic rdy_sync,
   output logic wr_accept,
   output logic latch_en,
   output logic dav_n_out,
   output logic rdy_out
);
   oh_state_e o_state;
   logic      dav_q;
   logic      in_full;
   logic      dav_fall;

   assign wr_accept = data_wr && (!out_hs || o_state == OH_IDLE);
   assign dav_n_out = (o_state != OH_WAIT_RDY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         o_state <= OH_IDLE;
      end else if (!out_hs) begin
         o_state <= OH_IDLE;
      end else begin
         unique case (o_state)
            OH_IDLE:     if (data_wr)   o_state <= OH_WAIT_RDY;
            OH_WAIT_RDY: if (rdy_sync)  o_state <= OH_WAIT_REL;
            OH_WAIT_REL: if (!rdy_sync) o_state <= OH_IDLE;
            default:                    o_state <= OH_IDLE;
         endcase
      end
   end

   assign dav_fall = dav_q && !dav_sync;
   assign latch_en = in_hs && !in_full && dav_fall;
   assign rdy_out  = !in_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dav_q   <= 1'b1;
         in_full <= 1'b0;
      end else begin
         dav_q <= dav_sync;
         if (!in_hs)                  in_full <= 1'b0;
         else if (latch_en)           in_full <= 1'b1;
         else if (in_full && rd_strobe) in_full <= 1'b0;
      end
   end
endmodule

// File: rtl/nibport.sv
module nibport
   import nibport_pkg::*;
#(
   parameter int       NIB_W       = 4,
   parameter int       SYNC_DEPTH  = 2,
   parameter bit [1:0] PULLUP_MASK = 2'b11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [2*NIB_W-1:0] wr_data,
   input  logic              rd_strobe,
   output logic [2*NIB_W-1:0] rd_data,
   input  logic [2*NIB_W-1:0] addr_nib,
   input  logic [2*NIB_W-1:0] pad_in,
   output logic [2*NIB_W-1:0] pad_out,
   output logic [2*NIB_W-1:0] pad_oe,
   output logic [2*NIB_W-1:0] pullup_en,
   input  logic              dav_n_in,
   output logic              dav_n_out,
   output logic              dav_oe,
   input  logic              rdy_in,
   output logic              rdy_out,
   output logic              rdy_oe
);
   localparam int NUM_NIB = 2;
   localparam int PW      = NUM_NIB * NIB_W;

   generate
      if (PW < CFG_W) begin : g_bad_width
         $error("nibport: port too narrow to hold the configuration word");
      end
      if (SYNC_DEPTH < 1) begin : g_bad_sync
         $error("nibport: SYNC_DEPTH must be at least 1");
      end
   endgenerate

   logic [CFG_W-1:0] mode_reg;
   logic [PW-1:0]    data_reg;
   logic [PW-1:0]    in_reg;
   nib_mode_e        up_m, lo_raw, lo_m;
   nib_mode_e        lane_mode [NUM_NIB];
   logic             hs_act, out_hs, in_hs;
   logic             dav_sync, rdy_sync;
   logic             data_wr, wr_accept, latch_en;

   // configuration decode
   assign up_m   = norm_mode(mode_reg[UP_LSB +: 2]);
   assign lo_raw = norm_mode(mode_reg[LO_LSB +: 2]);
   assign hs_act = mode_reg[HS_BIT] && (up_m != NM_ADDR);
   assign lo_m   = hs_act ? up_m : lo_raw;
   assign out_hs = hs_act && (up_m == NM_OUT);
   assign in_hs  = hs_act && (up_m == NM_IN);
   assign lane_mode[0] = lo_m;
   assign lane_mode[1] = up_m;

   assign data_wr = wr_en && wr_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_reg <= '0;
         data_reg <= '0;
      end else begin
         if (wr_en && !wr_sel) mode_reg <= wr_data[CFG_W-1:0];
         if (wr_accept)        data_reg <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      in_reg <= '0;
      else if (!in_hs) in_reg <= pad_in;
      else if (latch_en) in_reg <= pad_in;
   end
   assign rd_data = in_reg;

   // per-nibble pin muxes
   genvar gi;
   generate
      for (gi = 0; gi < NUM_NIB; gi++) begin : g_lane
         nibport_lane #(
            .NIB_W  (NIB_W),
            .PU_OPT (PULLUP_MASK[gi])
         ) lane_i (
            .mode      (lane_mode[gi]),
            .data_bits (data_reg[gi*NIB_W +: NIB_W]),
            .addr_bits (addr_nib[gi*NIB_W +: NIB_W]),
            .pin_out   (pad_out[gi*NIB_W +: NIB_W]),
            .pin_oe    (pad_oe[gi*NIB_W +: NIB_W]),
            .pu_en     (pullup_en[gi*NIB_W +: NIB_W])
         );
      end
   endgenerate

   // handshake pins
   nibport_sync #(.DEPTH(SYNC_DEPTH), .RST_VAL(1'b1)) dav_sync_i (
      .clk (clk), .rst_n (rst_n), .d (dav_n_in), .q (dav_sync)
   );
   nibport_sync #(.DEPTH(SYNC_DEPTH), .RST_VAL(1'b0)) rdy_sync_i (
      .clk (clk), .rst_n (rst_n), .d (rdy_in), .q (rdy_sync)
   );

   nibport_hs hs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .out_hs    (out_hs),
      .in_hs     (in_hs),
      .data_wr   (data_wr),
      .rd_strobe (rd_strobe),
      .dav_sync  (dav_sync),
      .rdy_sync  (rdy_sync),
      .wr_accept (wr_accept),
      .latch_en  (latch_en),
      .dav_n_out (dav_n_out),
      .rdy_out   (rdy_out)
   );

   assign dav_oe = out_hs;
   assign rdy_oe = in_hs;
endmodule

// File: rtl/nibport_chk.sv
module nibport_chk #(
   parameter int       PW          = 8,
   parameter bit [1:0] PULLUP_MASK = 2'b11
) (
   input logic          clk,
   input logic          rst_n,
   input logic [4:0]    mode_reg,
   input logic [PW-1:0] data_reg,
   input logic [PW-1:0] addr_nib,
   input logic [PW-1:0] pad_out,
   input logic [PW-1:0] pad_oe,
   input logic [PW-1:0] pullup_en,
   input logic          dav_n_out,
   input logic          dav_oe,
   input logic          rdy_out,
   input logic          rdy_oe,
   input logic          rdy_sync,
   input logic          dav_sync,
   input logic          wr_en,
   input logic          wr_sel,
   input logic          rd_strobe
);
   localparam int NW = PW / 2;

   AST_PU_OFF_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (pullup_en & pad_oe) == '0) else $error("pull-up on driven bit"); // R5

   AST_ADDR_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_reg[3:2] == 2'b10) |->
         (pad_oe[PW-1:NW] == '1 && pad_out[PW-1:NW] == addr_nib[PW-1:NW]))
      else $error("upper address drive"); // R3

   AST_HS_LOWER_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (dav_oe || rdy_oe) |-> (pad_oe[NW-1:0] == pad_oe[PW-1:NW]))
      else $error("lower nibble not following upper"); // R7

   AST_HS_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      !(dav_oe && rdy_oe)) else $error("both handshake lines driven"); // R7

   AST_DAV_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (dav_oe && $past(dav_oe) && $rose(dav_n_out)) |-> $past(rdy_sync))
      else $error("strobe released without ready"); // R8

   AST_WR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (dav_oe && !dav_n_out && wr_en && wr_sel) |=> $stable(data_reg))
      else $error("data write taken while strobe low"); // R9

   AST_RDY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_oe && $past(rdy_oe) && $fell(rdy_out)) |-> $past(!dav_sync))
      else $error("ready dropped without strobe"); // R10

   AST_RDY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_oe && $past(rdy_oe) && $rose(rdy_out)) |-> $past(rd_strobe))
      else $error("ready raised without acknowledge"); // R11
endmodule

bind nibport nibport_chk #(.PW(PW), .PULLUP_MASK(PULLUP_MASK)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_reg  (mode_reg),
   .data_reg  (data_reg),
   .addr_nib  (addr_nib),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .pullup_en (pullup_en),
   .dav_n_out (dav_n_out),
   .dav_oe    (dav_oe),
   .rdy_out   (rdy_out),
   .rdy_oe    (rdy_oe),
   .rdy_sync  (rdy_sync),
   .dav_sync  (dav_sync),
   .wr_en     (wr_en),
   .wr_sel    (wr_sel),
   .rd_strobe (rd_strobe)
);

// File: tb/nibport_tb_top.sv
`timescale 1ns/1ps
module nibport_tb_top;
   localparam int SD = 2;
   localparam logic [7:0] PU_NIB = 8'h0F;   // PULLUP_MASK = 2'b01

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, wr_sel = 1'b0, rd_strobe = 1'b0;
   logic [7:0] wr_data = '0, addr_nib = '0, pad_in = '0;
   logic [7:0] rd_data, pad_out, pad_oe, pullup_en;
   logic       dav_n_in = 1'b1, rdy_in = 1'b0;
   logic       dav_n_out, dav_oe, rdy_out, rdy_oe;
   int         errors = 0, checks = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   nibport #(.NIB_W(4), .SYNC_DEPTH(SD), .PULLUP_MASK(2'b01)) dut_i (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_sel (wr_sel),
      .wr_data (wr_data), .rd_strobe (rd_strobe), .rd_data (rd_data),
      .addr_nib (addr_nib), .pad_in (pad_in), .pad_out (pad_out),
      .pad_oe (pad_oe), .pullup_en (pullup_en), .dav_n_in (dav_n_in),
      .dav_n_out (dav_n_out), .dav_oe (dav_oe), .rdy_in (rdy_in),
      .rdy_out (rdy_out), .rdy_oe (rdy_oe)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_edges(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // expected pin state computed from the mode word
   function automatic void model(input logic [4:0] m, input logic [7:0] d, input logic [7:0] a,
                                 output logic [7:0] oe, output logic [7:0] o, output logic dv, output logic ry);
      logic [1:0] up, lo, nm;
      logic hs;
      up = (m[3:2] == 2'b11) ? 2'b00 : m[3:2];
      lo = (m[1:0] == 2'b11) ? 2'b00 : m[1:0];
      hs = m[4] && (up != 2'b10);
      if (hs) lo = up;
      oe = '0; o = '0;
      for (int n = 0; n < 2; n++) begin
         nm = (n == 0) ? lo : up;
         if (nm == 2'b01) begin oe[n*4 +: 4] = 4'hF; o[n*4 +: 4] = d[n*4 +: 4]; end
         if (nm == 2'b10) begin oe[n*4 +: 4] = 4'hF; o[n*4 +: 4] = a[n*4 +: 4]; end
      end
      dv = hs && (up == 2'b01);
      ry = hs && (up == 2'b00);
   endfunction

   task automatic sweep(input logic [7:0] d, input logic [7:0] a);
      logic [7:0] eoe, eo;
      logic edv, ery;
      wr(1'b0, 8'h00);
      wr(1'b1, d);
      addr_nib = a;
      for (int m = 0; m < 32; m++) begin
         wr(1'b0, 8'(m));
         model(5'(m), d, a, eoe, eo, edv, ery);
         check("R2 pad_oe", pad_oe, eoe);
         check("R3 pad_out", pad_out, eo);
         check("R5 pullup_en", pullup_en, ~eoe & PU_NIB);
         check("R7 dav_oe", dav_oe, edv);
         check("R7 rdy_oe", rdy_oe, ery);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      pad_in = 8'h5C;
      wait_edges(3);
      // R1: reset state
      check("R1 pad_oe", pad_oe, 8'h00);
      check("R1 rd_data", rd_data, 8'h00);
      check("R1 pullup_en", pullup_en, PU_NIB);
      check("R1 dav_oe", dav_oe, 1'b0);
      check("R1 rdy_oe", rdy_oe, 1'b0);
      check("R1 dav_n_out", dav_n_out, 1'b1);
      rst_n = 1'b1;
      wait_edges(2);

      // R4: lower address, upper output
      addr_nib = 8'h96;
      wr(1'b1, 8'hA5);
      wr(1'b0, 8'b0_01_10);
      check("R4 pad_oe", pad_oe, 8'hFF);
      check("R4 pad_out", pad_out, 8'hA6);
      wr(1'b0, 8'b0_00_10);
      check("R4 upper input", pad_oe, 8'h0F);
      check("R4 pad_out", pad_out, 8'h06);

      // R2/R3/R5/R7: full mode sweep, two data patterns
      sweep(8'hA5, 8'h96);
      sweep(8'h3C, 8'h69);

      // R6: input sampling, every pin value
      wr(1'b0, 8'h00);
      for (int v = 0; v < 256; v++) begin
         pad_in = 8'(v);
         @(negedge clk);
         check("R6 rd_data", rd_data, 32'(v));
      end

      // send handshake
      wr(1'b0, 8'b1_01_00);
      check("R7 lower follows out", pad_oe, 8'hFF);
      check("R8 dav idle", dav_n_out, 1'b1);
      wr(1'b1, 8'h5A);
      check("R8 dav low after write", dav_n_out, 1'b0);
      check("R8 data out", pad_out, 8'h5A);
      wr(1'b1, 8'hFF);
      check("R9 write blocked while dav low", pad_out, 8'h5A);
      rdy_in = 1'b1;
      for (int k = 1; k <= SD + 1; k++) begin
         @(negedge clk);
         check("R8 dav release timing", dav_n_out, (k == SD + 1));
      end
      wr(1'b1, 8'h11);
      check("R9 write blocked while rdy high", pad_out, 8'h5A);
      check("R9 dav stays high", dav_n_out, 1'b1);
      rdy_in = 1'b0;
      wait_edges(SD + 1);
      wr(1'b1, 8'h22);
      check("R9 write accepted after rdy low", pad_out, 8'h22);
      check("R8 dav low again", dav_n_out, 1'b0);
      rdy_in = 1'b1;
      wait_edges(SD + 1);
      check("R8 dav released", dav_n_out, 1'b1);
      rdy_in = 1'b0;
      wait_edges(SD + 1);

      // receive handshake
      wr(1'b0, 8'b1_00_01);
      check("R7 lower follows in", pad_oe, 8'h00);
      check("R10 rdy idle high", rdy_out, 1'b1);
      check("R10 rdy_oe", rdy_oe, 1'b1);
      pad_in = 8'hC3;
      dav_n_in = 1'b0;
      for (int k = 1; k <= SD + 1; k++) begin
         @(negedge clk);
         check("R10 rdy drop timing", rdy_out, (k < SD + 1));
      end
      check("R10 data latched", rd_data, 8'hC3);
      pad_in = 8'h7E;
      dav_n_in = 1'b1;
      wait_edges(SD + 1);
      dav_n_in = 1'b0;
      wait_edges(SD + 2);
      check("R11 second fall ignored", rd_data, 8'hC3);
      check("R11 rdy held low", rdy_out, 1'b0);
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      check("R11 rdy after ack", rdy_out, 1'b1);
      check("R11 data kept", rd_data, 8'hC3);
      dav_n_in = 1'b1;
      wait_edges(SD + 1);
      dav_n_in = 1'b0;
      wait_edges(SD + 1);
      check("R10 next byte", rd_data, 8'h7E);
      check("R10 rdy low again", rdy_out, 1'b0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule